// File: doc/BRIEF.md
# Compare and Edge PWM Timer

This block is an up-counting timer with a programmable wrap value and a parameterised number of output channels. While its run bit is set, the counter steps by one on every clock, and after reaching the wrap value it returns to zero. Each channel drives one pin. The pin works in one of two ways. In compare mode it is set, cleared or inverted when the counter reaches the channel's compare value. In edge PWM mode it rises as the counter passes through zero and falls on the compare match.

Software uses a synchronous write port to program the run bit, the wrap value, and each channel's configuration and compare value. The live count can be read back at any time. New wrap and compare values do not act on the counter at the moment they are written. They sit in a holding register and are copied into the working register on the next counter advance. This lets software retarget a channel in mid-period without a glitch. A compare value above the wrap value never matches, so it can be used to park a channel: the pin then keeps its level until a real value is loaded.

Each pin is registered. Its level is computed from the count the counter is about to take, so a pin edge appears in the same cycle as the matching count on `count_o`.

Top module: `cmpwm_timer`

## Requirements
- R1: After reset, `count_o`, `ch_out` and `ch_oe` are all zero, and every working compare value is zero. A channel set to set-on-match therefore rises the first time the counter wraps to zero.
- R2: The run bit is bit 0 at address 0. While it is clear, the counter is forced to zero and stays there. While it is set, the counter steps by one per clock, and a count at or above the working wrap value is followed by zero. A write to the run bit first affects the counter at the clock after the write.
- R3: The wrap value is written at address 1 into a holding register. The first counter advance after the write still uses the old wrap value. That advance copies the new value into the working register, and it governs every later advance.
- R4: The compare value of channel k is written at address 3+2k into a holding register. It is copied into the working register by the first counter advance after the write. The count produced by that same advance is matched against the new value, and the count produced in the write cycle is matched against the old one.
- R5: The configuration of channel k is at address 2+2k: bits [1:0] are the mode (00 off, 01 toggle, 10 clear, 11 set) and bit 2 selects edge PWM. With mode 11 and PWM clear, the pin is 1 from the cycle in which `count_o` equals the compare value, and it keeps its level otherwise.
- R6: With mode 10 and PWM clear, the pin is 0 from the cycle in which `count_o` equals the compare value, and it keeps its level otherwise.
- R7: With mode 01 and PWM clear, the pin inverts in the cycle in which `count_o` equals the compare value, once per match.
- R8: A compare value greater than the wrap value never matches, so in compare mode the pin holds its level across whole periods.
- R9: With bit 2 set (mode bits ignored), the pin is 1 from the cycle in which `count_o` becomes zero and 0 from the cycle in which `count_o` equals the compare value.
- R10: In PWM mode a compare value of zero keeps the pin at 0, because the match wins over the wrap. A compare value above the wrap value keeps it at 1.
- R11: With mode 00 and PWM clear, `ch_oe` and `ch_out` of that channel are 0. Moving a channel between the set, clear and toggle modes keeps `ch_oe` at 1 and leaves the pin level unchanged until the next match.
- R12: While the counter is stopped, no match is evaluated. Pin levels hold, even when compare values are rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Live counter value |
| ch_out | output | NUM_CH | Pin level per channel, 0 when not driven |
| ch_oe | output | NUM_CH | Pin drive enable per channel |

## Verification
The match properties assume the channel configuration did not change on the clock that produced the current count, because a configuration written on that edge only affects the next evaluation. The stimulus writes configurations well away from match counts, and compare and wrap values are only changed while the new load point is known. The wrap and step properties assume the counter has advanced from a known state, so each property conditions on the run bit held before the edge, and the bench changes the run bit only through the ordinary write port.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

   typedef enum logic [1:0] {
      OC_OFF    = 2'b00,
      OC_TOGGLE = 2'b01,
      OC_CLEAR  = 2'b10,
      OC_SET    = 2'b11
   } oc_mode_e;

   typedef struct packed {
      logic     pwm;
      oc_mode_e mode;
   } ch_cfg_t;

   localparam int CFG_W       = $bits(ch_cfg_t);
   localparam int ADR_CTRL    = 0;
   localparam int ADR_MOD     = 1;
   localparam int ADR_CH_BASE = 2;
   localparam int ADR_CH_STEP = 2;

endpackage

// File: rtl/cmpwm_regdec.sv
module cmpwm_regdec #(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 3
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              ctrl_we,
   output logic              mod_we,
   output logic [NUM_CH-1:0] cfg_we,
   output logic [NUM_CH-1:0] cmp_we
);
   import cmpwm_pkg::*;

   assign ctrl_we = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
   assign mod_we  = wr_en && (wr_addr == ADDR_W'(ADR_MOD));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
      localparam int CFG_ADR = ADR_CH_BASE + ADR_CH_STEP * k;
      localparam int CMP_ADR = CFG_ADR + 1;
      assign cfg_we[k] = wr_en && (wr_addr == ADDR_W'(CFG_ADR));
      assign cmp_we[k] = wr_en && (wr_addr == ADDR_W'(CMP_ADR));
   end

endmodule

// File: rtl/cmpwm_counter.sv
module cmpwm_counter #(
   parameter int             CNT_W    = 16,
   parameter logic [CNT_W-1:0] MOD_INIT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             mod_we,
   input  logic [CNT_W-1:0] mod_wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [CNT_W-1:0] mod_act
);

   logic [CNT_W-1:0] mod_buf;

   // wrap decision uses the working value; holding value is taken on advance
   always_comb begin
      if (cnt_q >= mod_act) cnt_nxt = '0;
      else                  cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         mod_buf <= MOD_INIT;
         mod_act <= MOD_INIT;
      end else begin
         if (mod_we) mod_buf <= mod_wdata;
         if (run) begin
            cnt_q   <= cnt_nxt;
            mod_act <= mod_buf;
         end else begin
            cnt_q   <= '0;
         end
      end
   end

endmodule

// File: rtl/cmpwm_channel.sv
module cmpwm_channel #(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic [CNT_W-1:0]    cnt_nxt,
   input  logic                cfg_we,
   input  logic                cmp_we,
   input  logic [CNT_W-1:0]    wdata,
   output logic                pin_out,
   output logic                pin_oe,
   output cmpwm_pkg::ch_cfg_t  cfg_o,
   output logic [CNT_W-1:0]    cmp_act_o
);
   import cmpwm_pkg::*;

   ch_cfg_t          cfg_q;
   logic [CNT_W-1:0] cmp_buf;
   logic [CNT_W-1:0] cmp_act;
   logic             pin_q;
   logic             pin_d;
   logic             hit;

   // the value about to become working is matched against the count about to appear
   assign hit = (cnt_nxt == cmp_buf);

   always_comb begin
      pin_d = pin_q;
      if (cfg_q.pwm) begin
         if (hit)                 pin_d = 1'b0;
         else if (cnt_nxt == '0)  pin_d = 1'b1;
      end else begin
         unique case (cfg_q.mode)
            OC_TOGGLE: if (hit) pin_d = ~pin_q;
            OC_CLEAR:  if (hit) pin_d = 1'b0;
            OC_SET:    if (hit) pin_d = 1'b1;
            default:   pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         cmp_buf <= '0;
         cmp_act <= '0;
         pin_q   <= 1'b0;
      end else begin
         if (cfg_we) cfg_q   <= ch_cfg_t'(wdata[CFG_W-1:0]);
         if (cmp_we) cmp_buf <= wdata;
         if (adv) begin
            cmp_act <= cmp_buf;
            pin_q   <= pin_d;
         end
      end
   end

   assign pin_oe    = cfg_q.pwm || (cfg_q.mode != OC_OFF);
   assign pin_out   = pin_q && pin_oe;
   assign cfg_o     = cfg_q;
   assign cmp_act_o = cmp_act;

endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer
   import cmpwm_pkg::*;
#(
   parameter int               CNT_W    = 16,
   parameter int               NUM_CH   = 2,
   parameter int               ADDR_W   = $clog2(ADR_CH_BASE + ADR_CH_STEP * NUM_CH),
   parameter logic [CNT_W-1:0] MOD_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [NUM_CH-1:0] ch_out,
   output logic [NUM_CH-1:0] ch_oe
);

   localparam int N_ADR = ADR_CH_BASE + ADR_CH_STEP * NUM_CH;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("cmpwm_timer: NUM_CH must be at least 2");
   end
   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_w
      $error("cmpwm_timer: CNT_W must lie in 4..32");
   end
   if ((1 << ADDR_W) < N_ADR) begin : g_bad_a
      $error("cmpwm_timer: ADDR_W too small for the register map");
   end

   logic                      ctrl_we;
   logic                      mod_we;
   logic [NUM_CH-1:0]         cfg_we;
   logic [NUM_CH-1:0]         cmp_we;
   logic                      run_q;
   logic [CNT_W-1:0]          cnt_nxt;
   logic [CNT_W-1:0]          mod_act;
   logic [CFG_W*NUM_CH-1:0]   cfg_flat;
   logic [CNT_W*NUM_CH-1:0]   cmp_flat;

   cmpwm_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .ctrl_we (ctrl_we),
      .mod_we  (mod_we),
      .cfg_we  (cfg_we),
      .cmp_we  (cmp_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 1'b0;
      else if (ctrl_we) run_q <= wr_data[0];
   end

   cmpwm_counter #(.CNT_W(CNT_W), .MOD_INIT(MOD_INIT)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .mod_we    (mod_we),
      .mod_wdata (wr_data),
      .cnt_q     (count_o),
      .cnt_nxt   (cnt_nxt),
      .mod_act   (mod_act)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      ch_cfg_t          cfg_k;
      logic [CNT_W-1:0] cmp_k;

      cmpwm_channel #(.CNT_W(CNT_W)) ch_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .adv       (run_q),
         .cnt_nxt   (cnt_nxt),
         .cfg_we    (cfg_we[k]),
         .cmp_we    (cmp_we[k]),
         .wdata     (wr_data),
         .pin_out   (ch_out[k]),
         .pin_oe    (ch_oe[k]),
         .cfg_o     (cfg_k),
         .cmp_act_o (cmp_k)
      );

      assign cfg_flat[k*CFG_W +: CFG_W] = cfg_k;
      assign cmp_flat[k*CNT_W +: CNT_W] = cmp_k;
   end

endmodule

// File: rtl/cmpwm_timer_chk.sv
module cmpwm_timer_chk #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    run_q,
   input logic [CNT_W-1:0]        count_o,
   input logic [CNT_W-1:0]        mod_act,
   input logic [3*NUM_CH-1:0]     cfg_flat,
   input logic [CNT_W*NUM_CH-1:0] cmp_flat,
   input logic [NUM_CH-1:0]       ch_out
);

   assert_stop_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (count_o == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && (count_o < mod_act)) |=> (count_o == $past(count_o) + 1'b1));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && (count_o >= mod_act)) |=> (count_o == '0));

   // R12: a stopped counter leaves every pin alone
   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run_q) && $stable(cfg_flat)) |-> $stable(ch_out));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [2:0]       cfg_k;
      logic [CNT_W-1:0] cmp_k;
      logic             at_cmp;
      assign cfg_k  = cfg_flat[3*k +: 3];
      assign cmp_k  = cmp_flat[CNT_W*k +: CNT_W];
      assign at_cmp = (count_o == cmp_k);

      assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(run_q) && $stable(cfg_k) && (cfg_k == 3'b011) && at_cmp) |-> ch_out[k]);

      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(run_q) && $stable(cfg_k) && (cfg_k == 3'b010) && at_cmp) |-> !ch_out[k]);

      assert_pwm_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(run_q) && $stable(cfg_k) && cfg_k[2] && at_cmp) |-> !ch_out[k]);

      assert_pwm_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(run_q) && $stable(cfg_k) && cfg_k[2] && (count_o == '0) && (cmp_k != '0))
         |-> ch_out[k]);
   end

endmodule

bind cmpwm_timer cmpwm_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_q    (run_q),
   .count_o  (count_o),
   .mod_act  (mod_act),
   .cfg_flat (cfg_flat),
   .cmp_flat (cmp_flat),
   .ch_out   (ch_out)
);

// File: tb/cmpwm_timer_tb_top.sv
module cmpwm_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int NUM_CH     = 2;
   localparam int ADDR_W     = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_MOD  = 3'd1;
   localparam logic [ADDR_W-1:0] A_CFG0 = 3'd2;
   localparam logic [ADDR_W-1:0] A_CMP0 = 3'd3;
   localparam logic [ADDR_W-1:0] A_CFG1 = 3'd4;
   localparam logic [ADDR_W-1:0] A_CMP1 = 3'd5;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [CNT_W-1:0]  wr_data;
   logic [CNT_W-1:0]  count_o;
   logic [NUM_CH-1:0] ch_out;
   logic [NUM_CH-1:0] ch_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmpwm_timer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count_o(count_o), .ch_out(ch_out), .ch_oe(ch_oe)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      tick();
      wr_en   = 1'b0;
   endtask

   task automatic wait_count(input int v);
      for (int i = 0; i < 300; i++) begin
         if (count_o == CNT_W'(v)) return;
         tick();
      end
      check("R2", "count never reached", count_o, v);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   // R1: reset state, then reset compare value zero matches at the first wrap
   task automatic t_reset();
      check("R1", "count after reset", count_o, 0);
      check("R1", "ch_out after reset", ch_out, 0);
      check("R1", "ch_oe after reset", ch_oe, 0);
      wr(A_CFG0, 16'd3);
      wr(A_MOD, 16'd9);
      wr(A_CTRL, 16'd1);
      wait_count(9);
      check("R1", "ch0 before wrap", ch_out[0], 0);
      tick();
      check("R1", "ch0 at count 0 with reset compare", ch_out[0], 1);
   endtask

   // R2: stop forces zero, restart counts 0..9 and wraps
   task automatic t_count();
      wr(A_CTRL, 16'd0);
      tick();
      check("R2", "count after stop", count_o, 0);
      repeat (3) tick();
      check("R2", "count held while stopped", count_o, 0);
      wr(A_CTRL, 16'd1);
      check("R2", "count on run write edge", count_o, 0);
      for (int k = 1; k <= 25; k++) begin
         tick();
         check("R2", "count sequence", count_o, k % 10);
      end
   endtask

   // R3: wrap value load on next advance
   task automatic t_mod();
      wait_count(5);
      wr(A_MOD, 16'd6);
      check("R3", "count on write edge", count_o, 6);
      tick();
      check("R3", "old wrap for first advance", count_o, 7);
      tick();
      check("R3", "new wrap applied", count_o, 0);
      repeat (6) tick();
      check("R3", "count at new wrap", count_o, 6);
      tick();
      check("R3", "wrap at 6", count_o, 0);
      wr(A_MOD, 16'd19);
      wait_count(19);
      tick();
      check("R3", "wrap at 19", count_o, 0);
   endtask

   // R4, R5, R6, R11: deferred compare loads and set/clear matches
   task automatic t_compare();
      wr(A_CMP0, 16'h3F);
      wr(A_CFG0, 16'd2);
      check("R11", "ch0 oe after set->clear", ch_oe[0], 1);
      check("R11", "ch0 level kept after set->clear", ch_out[0], 1);
      wait_count(3);
      wr(A_CMP0, 16'd4);
      check("R4", "no match on write-cycle count", ch_out[0], 1);
      wait_count(3);
      check("R6", "ch0 before clear match", ch_out[0], 1);
      tick();
      check("R6", "ch0 cleared at count 4", ch_out[0], 0);
      tick();
      check("R6", "ch0 stays low", ch_out[0], 0);
      wr(A_CFG0, 16'd3);
      check("R11", "ch0 level kept after clear->set", ch_out[0], 0);
      wait_count(10);
      wr(A_CMP0, 16'd12);
      check("R5", "ch0 low at count 11", ch_out[0], 0);
      tick();
      check("R4", "new compare used from next advance", ch_out[0], 1);
   endtask

   // R8: parked compare never matches
   task automatic t_park();
      bit bad = 0;
      wr(A_CMP0, 16'h3F);
      wr(A_CFG0, 16'd2);
      for (int i = 0; i < 45; i++) begin
         tick();
         if (ch_out[0] !== 1'b1) bad = 1;
      end
      check("R8", "parked clear channel held high", bad, 0);
   endtask

   // R7: toggle once per match
   task automatic t_toggle();
      logic v;
      wr(A_CMP1, 16'd7);
      wr(A_CFG1, 16'd1);
      wait_count(0);
      wait_count(6);
      v = ch_out[1];
      tick();
      check("R7", "toggle at count 7", ch_out[1], !v);
      wait_count(6);
      check("R7", "level held through period", ch_out[1], !v);
      tick();
      check("R7", "toggle back at count 7", ch_out[1], v);
   endtask

   // R9, R10: edge PWM
   task automatic t_pwm();
      bit bad;
      wr(A_CMP1, 16'd5);
      wr(A_CFG1, 16'd4);
      wait_count(19);
      tick();
      check("R9", "pwm high at count 0", ch_out[1], 1);
      wait_count(4);
      check("R9", "pwm high at count 4", ch_out[1], 1);
      tick();
      check("R9", "pwm low at count 5", ch_out[1], 0);
      wait_count(19);
      check("R9", "pwm low at count 19", ch_out[1], 0);
      tick();
      check("R9", "pwm high after wrap", ch_out[1], 1);
      wr(A_CMP1, 16'd0);
      wait_count(19);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (ch_out[1] !== 1'b0) bad = 1;
      end
      check("R10", "pwm compare 0 stays low", bad, 0);
      wr(A_CMP1, 16'h3F);
      wait_count(19);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (ch_out[1] !== 1'b1) bad = 1;
      end
      check("R10", "pwm compare above wrap stays high", bad, 0);
   endtask

   // R11: off mode releases the pin
   task automatic t_off();
      wr(A_CFG0, 16'd0);
      check("R11", "ch0 oe when off", ch_oe[0], 0);
      check("R11", "ch0 out when off", ch_out[0], 0);
      wr(A_CFG0, 16'd3);
      check("R11", "ch0 oe back in set mode", ch_oe[0], 1);
   endtask

   // R12: stopped counter evaluates no match
   task automatic t_stop();
      logic v0;
      bit bad = 0;
      wr(A_CTRL, 16'd0);
      tick();
      v0 = ch_out[0];
      wr(A_CMP1, 16'd0);
      wr(A_CMP0, 16'd0);
      for (int i = 0; i < 6; i++) begin
         tick();
         if (count_o !== '0 || ch_out[1] !== 1'b1 || ch_out[0] !== v0) bad = 1;
      end
      check("R12", "pins held while stopped", bad, 0);
   endtask

   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      tick();
      t_reset();
      t_count();
      t_mod();
      t_compare();
      t_park();
      t_toggle();
      t_pwm();
      t_off();
      t_stop();
      if (!done) begin
         done = 1;
         report();
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         report();
         $finish;
      end
   end

endmodule